// File: doc/BRIEF.md
# Sequenced Status Packet Generator

This block turns a 26-bit status word into a short byte-serial packet for an upstream status collector. When a report is due it raises a request and shows a fixed address byte on its 8-bit output. Once the collector acknowledges that address byte, four body bytes follow on consecutive cycles. The body is taken from a single snapshot of the status word and of a 6-bit sequence number.

An 8-bit write port sets the reporting mode and the sequence number. The mode field selects one of these behaviours:
- off;
- one report per write;
- automatic reporting whenever the status differs from the last value sent.

The sequence number lets software match each received report to the write that caused it.

Top module: `stat_pkt_gen`

## Requirements
- R1: After synchronous reset, `req` is low and `pkt_byte` is 0x00. The mode is off and the sequence number is 0.
- R2: A write with `wr_en` high loads the mode from `wr_data[1:0]` and the sequence number from `wr_data[7:2]`. Mode codes are 0 = off, 1 = single report, 2 = automatic and 3 = reserved, which behaves as off.
- R3: While a report is pending and no packet is streaming, `req` is high and `pkt_byte` shows `ADDR_BYTE` (default 0x21). With no packet streaming and `req` low, `pkt_byte` is 0x00.
- R4: A clock edge with `req` and `ack_start` both high accepts the packet. On the four following cycles `pkt_byte` carries, in order:
  - `{seq[5:0], status[1:0]}`;
  - `status[9:2]`;
  - `status[17:10]`;
  - `status[25:18]`.

  After that, `pkt_byte` returns to idle.
- R5: `req` is low from the cycle after acceptance until the fourth body byte has been shown.
- R6: The status word and the sequence number are captured at the accepting edge. Changes to either while the body is streaming do not alter the bytes of that packet.
- R7: In single-report mode, exactly one packet is requested per write. After it is accepted, `req` stays low until the mode register is written again.
- R8: Writing automatic mode requests one report at once. After that, any status value that differs from the last snapshot sent raises `req` on the following cycle.
- R9: In automatic mode, a status change that occurs while a packet streams raises `req` again once that packet ends. The new packet carries the status sampled at its own acceptance.
- R10: Writing mode 0 or 3 withdraws a pending, unaccepted request on the next cycle, and no report is requested while the mode is 0 or 3.
- R11: `ack_start` asserted while `req` is low starts no packet and leaves `pkt_byte` at 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the mode/sequence register |
| wr_data | input | 8 | Bits 1:0 mode, bits 7:2 sequence number |
| status | input | 26 | Status word to report |
| ack_start | input | 1 | Collector acknowledge of the address byte |
| req | output | 1 | Report request |
| pkt_byte | output | 8 | Packet byte stream |

## Verification
On every cycle, assertions check the following:
- acceptance always starts a body of exactly the expected length and drops the request;
- the captured snapshot stays still while the body streams;
- off and reserved modes never hold a pending report;
- a single report does not rearm by itself;
- in automatic mode, a status difference while idle always produces a request;
- a stray acknowledge never starts a packet.

Only the bench scenarios can show the byte values themselves. This covers the field packing of the status and sequence bits, immunity to changes in the middle of a packet, and the order of a report that follows one in flight. Randomised status sequences in automatic mode cover arbitrary acknowledge delays.

// File: rtl/stat_pkt_pkg.sv
package stat_pkt_pkg;
  localparam int ST_W       = 26;
  localparam int SEQ_W      = 6;
  localparam int BODY_BYTES = 4;
  localparam int IDX_W      = $clog2(BODY_BYTES + 1);

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ONCE = 2'd1,
    MODE_AUTO = 2'd2,
    MODE_RSVD = 2'd3
  } rep_mode_e;

  // Body byte number idx (1..BODY_BYTES) of a packet
  function automatic logic [7:0] body_byte(input logic [IDX_W-1:0] idx,
                                           input logic [SEQ_W-1:0] seq,
                                           input logic [ST_W-1:0]  st);
    case (idx)
      3'd1:    body_byte = {seq, st[1:0]};
      3'd2:    body_byte = st[9:2];
      3'd3:    body_byte = st[17:10];
      3'd4:    body_byte = st[25:18];
      default: body_byte = 8'h00;
    endcase
  endfunction

  function automatic logic mode_reports(input logic [1:0] m);
    mode_reports = (m == MODE_ONCE) || (m == MODE_AUTO);
  endfunction
endpackage

// File: rtl/stat_pkt_ctrl.sv
module stat_pkt_ctrl
  import stat_pkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             take,
  input  logic             changed,
  output rep_mode_e        mode,
  output logic [SEQ_W-1:0] seq,
  output logic             pending
);
  logic mode_off;
  assign mode_off = !mode_reports(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_OFF;
      seq     <= '0;
      pending <= 1'b0;
    end else begin
      if (wr_en) begin
        mode <= rep_mode_e'(wr_data[1:0]);
        seq  <= wr_data[7:2];
      end
      if (wr_en)                                pending <= mode_reports(wr_data[1:0]);
      else if (take)                            pending <= 1'b0;
      else if ((mode == MODE_AUTO) && changed)  pending <= 1'b1;
    end
  end

  // R10
  off_no_pending_chk: assert property (@(posedge clk) disable iff (rst)
    mode_off |-> !pending);

  // R7
  once_no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_ONCE) && !pending && !wr_en) |=> !pending);
endmodule

// File: rtl/stat_pkt_ser.sv
module stat_pkt_ser
  import stat_pkt_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE = 8'h21
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             req,
  input  logic [ST_W-1:0]  status,
  input  logic [SEQ_W-1:0] seq,
  output logic             busy,
  output logic [ST_W-1:0]  snap,
  output logic [7:0]       pkt_byte
);
  logic [IDX_W-1:0] idx;
  logic [SEQ_W-1:0] seq_snap;
  logic             last_byte;

  assign last_byte = (idx == IDX_W'(BODY_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      snap     <= '0;
      seq_snap <= '0;
    end else if (take) begin
      busy     <= 1'b1;
      idx      <= IDX_W'(1);
      snap     <= status;
      seq_snap <= seq;
    end else if (busy) begin
      if (last_byte) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx  <= idx + IDX_W'(1);
      end
    end
  end

  always_comb begin
    if (busy)     pkt_byte = body_byte(idx, seq_snap, snap);
    else if (req) pkt_byte = ADDR_BYTE;
    else          pkt_byte = 8'h00;
  end

  // R4
  body_start_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (busy && (idx == IDX_W'(1))));

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (idx != IDX_W'(1))) |-> ($stable(snap) && $stable(seq_snap)));
endmodule

// File: rtl/stat_pkt_gen.sv
module stat_pkt_gen
  import stat_pkt_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE = 8'h21
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic [25:0] status,
  input  logic        ack_start,
  output logic        req,
  output logic [7:0]  pkt_byte
);
  rep_mode_e        mode;
  logic [SEQ_W-1:0] seq;
  logic             pending;
  logic             busy;
  logic [ST_W-1:0]  snap;
  logic             take;
  logic             changed;

  assign req     = pending && !busy;
  assign take    = req && ack_start;
  assign changed = (status != snap);

  stat_pkt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .changed (changed),
    .mode    (mode),
    .seq     (seq),
    .pending (pending)
  );

  stat_pkt_ser #(.ADDR_BYTE(ADDR_BYTE)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .req      (req),
    .status   (status),
    .seq      (seq),
    .busy     (busy),
    .snap     (snap),
    .pkt_byte (pkt_byte)
  );

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !req);

  // R11
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_start && !req && !busy) |=> !busy);

  // R8
  auto_change_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_AUTO) && !busy && !pending && !wr_en && changed) |=> req);
endmodule

// File: tb/tb_stat_pkt_gen.sv
module tb_stat_pkt_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [25:0] status = '0;
  logic        ack_start = 1'b0;
  logic        req;
  logic [7:0]  pkt_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stat_pkt_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .ack_start(ack_start), .req(req), .pkt_byte(pkt_byte)
  );

  // Expected body byte k (1..4): first byte packs seq over the two status LSBs,
  // later bytes are successive 8-bit slices starting at status bit 2.
  function automatic logic [7:0] exp_body(int k, logic [5:0] sq, logic [25:0] st);
    logic [23:0] upper;
    upper = st[25:2];
    if (k == 1) return {sq, st[1:0]};
    return 8'((upper >> (8 * (k - 2))) & 24'hff);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] m, logic [5:0] sq);
    wr_en = 1'b1;
    wr_data = {sq, m};
    tick();
    wr_en = 1'b0;
  endtask

  // Accept the pending packet and check its body; optionally disturb inputs mid-stream.
  task automatic take_pkt(string tag, logic [5:0] sq, bit disturb, logic [25:0] newst);
    logic [25:0] cap;
    cap = status;
    ack_start = 1'b1;
    tick();
    ack_start = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      chk({tag, " R4 body"}, pkt_byte, exp_body(k, sq, cap));
      chk({tag, " R5 req low"}, {7'd0, req}, 8'd0);
      if (k == 1 && disturb) begin
        status = newst;
        wr_en = 1'b1;
        wr_data = {~sq, 2'd2};
        tick();
        wr_en = 1'b0;
      end else if (k < 4) begin
        tick();
      end
    end
    tick();
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [25:0] st;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 req", {7'd0, req}, 8'd0);
    chk("R1 byte", pkt_byte, 8'h00);

    // R11: stray acknowledge while idle
    ack_start = 1'b1; tick(); ack_start = 1'b0;
    chk("R11 byte", pkt_byte, 8'h00);
    tick();
    chk("R11 still idle", pkt_byte, 8'h00);

    // R2/R3: single report request with address byte
    status = 26'h2A5_C3F1;
    wr(2'd1, 6'h15);
    chk("R3 req", {7'd0, req}, 8'd1);
    chk("R3 addr byte", pkt_byte, 8'h21);
    chk("R2 seq in first byte", exp_body(1, 6'h15, status), {6'h15, status[1:0]});
    // R6: status and seq disturbed mid-stream
    take_pkt("R6", 6'h15, 1'b1, 26'h155_5555);
    // the disturbing write was mode 2 -> request for the new status follows
    chk("R8 auto write req", {7'd0, req}, 8'd1);
    take_pkt("R8", ~6'h15, 1'b0, '0);

    // R7: single mode does not rearm
    wr(2'd1, 6'h03);
    take_pkt("R7", 6'h03, 1'b0, '0);
    status = 26'h3FF_FFFF;
    repeat (5) tick();
    chk("R7 no rearm", {7'd0, req}, 8'd0);

    // R10: withdraw with mode 0 and with mode 3
    wr(2'd1, 6'h01);
    chk("R10 pre req", {7'd0, req}, 8'd1);
    wr(2'd0, 6'h01);
    chk("R10 off withdraws", {7'd0, req}, 8'd0);
    wr(2'd1, 6'h01);
    wr(2'd3, 6'h01);
    chk("R10 rsvd withdraws", {7'd0, req}, 8'd0);
    status = 26'h000_1234;
    repeat (3) tick();
    chk("R10 rsvd no change report", {7'd0, req}, 8'd0);
    chk("R10 idle byte", pkt_byte, 8'h00);

    // R8: automatic mode, change while idle
    wr(2'd2, 6'h2C);
    take_pkt("R8 initial", 6'h2C, 1'b0, '0);
    tick();
    chk("R8 no change no req", {7'd0, req}, 8'd0);
    status = 26'h0AB_CDEF;
    tick();
    chk("R8 change req", {7'd0, req}, 8'd1);

    // R9: change during transmission -> follow-up packet
    ack_start = 1'b1; tick(); ack_start = 1'b0;
    chk("R9 first body", pkt_byte, exp_body(1, 6'h2C, 26'h0AB_CDEF));
    status = 26'h123_4567;
    repeat (3) tick();
    tick();
    chk("R9 follow-up req", {7'd0, req}, 8'd1);
    take_pkt("R9 follow-up", 6'h2C, 1'b0, '0);

    // Random phase in automatic mode
    void'($urandom(32'd1234));
    for (int it = 0; it < 40; it++) begin
      st = 26'($urandom());
      if (st == status) st = ~st;
      status = st;
      for (int w = 0; w < 10 && !req; w++) tick();
      chk("R8 random req", {7'd0, req}, 8'd1);
      repeat ($urandom_range(0, 3)) tick();
      chk("R3 random addr", pkt_byte, 8'h21);
      take_pkt("R4 random", 6'h2C, 1'b0, '0);
      chk("R8 quiet after send", {7'd0, req}, 8'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule